// File: doc/BRIEF.md
# Parallel Flash Image Programming Sequencer

This block drives the parallel programming port of a byte-wide flash array from the host side and writes a complete image into it. A run begins with a one-cycle start pulse. An optional identity check reads two signature bytes first. An optional whole-array erase follows. The block then loops over the image. For each byte it fetches the byte from a local image buffer, sets up the port in a fixed order, pulses the program strobe, waits until the self-timed write has completed, and can read the byte back to verify it.

Write completion is detected in one of two ways, chosen per run. In polling mode the block reads the same address and waits until the top data bit stops showing its complement. In ready/busy mode it waits for the busy line to drop and then rise again. A timeout, a verify mismatch or a wrong signature ends the run. In each case the error flag is raised and the offending flash address is latched.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset and between runs, busy, done and error are low, the strobe is high (inactive), the high-voltage enable is low, the port mode is 0 (idle) and the data drivers are off.
- R2: With the identity check on, the block reads address SIG_BASE (0x030) and then SIG_BASE+1 (0x031) in port mode 4 (signature read). It expects 0x1E and then 0x51. On a mismatch it stops with done and error set, err_addr set to the address that was read, and no strobe pulse.
- R3: With erase on, the block applies port mode 3 (erase) and holds the strobe low for exactly ERASE_CYC cycles, once per run, before any byte is written.
- R4: For each byte the block first sets the address. After SETUP_CYC cycles it enables the data drivers. After another SETUP_CYC cycles it applies port mode 1 (write). If high voltage is configured, it then raises the high-voltage enable for SETUP_CYC cycles. Only after these steps does it give exactly one strobe-low pulse of STROBE_CYC cycles. Address and data stay stable during that pulse.
- R5: Bytes are requested with fetch_req, using fetch_addr equal to the flash address, and are taken on fetch_ack. The written addresses run upward from img_start, one strobe pulse per byte, for img_len bytes.
- R6: In polling mode (cfg_poll=1) the block reads the address just written in port mode 2. It treats the write as complete when read bit 7 equals written bit 7.
- R7: In ready/busy mode (cfg_poll=0) a write is complete only after fl_rdy has been seen low and then high. The next strobe pulse never starts while the array is still busy.
- R8: If completion is not seen within TIMEOUT_CYC cycles of waiting, the run stops with error set and err_addr equal to the byte's address.
- R9: With verify on, each byte is read back in port mode 2 after completion. A mismatch stops the run with error set and err_addr at that byte, and no further strobe pulse follows.
- R10: The high-voltage enable rises only in runs started with cfg_hv=1, and then during the erase hold and every write pulse.
- R11: With img_len equal to zero, the run ends with done set and no write pulse.
- R12: done and error are levels that hold until the next start. Start clears done on the following cycle and raises busy. error is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request, taken only while idle |
| cfg_ident | input | 1 | Run the signature check first |
| cfg_erase | input | 1 | Erase the whole array before programming |
| cfg_verify | input | 1 | Read back each byte after its write |
| cfg_hv | input | 1 | Use the high-voltage program enable |
| cfg_poll | input | 1 | 1: data polling, 0: ready/busy line |
| img_start | input | ADDR_W | First flash/image address |
| img_len | input | ADDR_W+1 | Number of bytes to write |
| fetch_req | output | 1 | Image byte request |
| fetch_addr | output | ADDR_W | Address of requested image byte |
| fetch_ack | input | 1 | Image byte valid this cycle |
| fetch_data | input | DATA_W | Image byte |
| fl_addr | output | ADDR_W | Flash address lines |
| fl_dout | output | DATA_W | Data driven to the flash |
| fl_dout_en | output | 1 | Data driver enable |
| fl_din | input | DATA_W | Data read from the flash |
| fl_mode | output | 3 | Control combination: 0 idle, 1 write, 2 read, 3 erase, 4 signature |
| fl_strobe_n | output | 1 | Program strobe, active low |
| fl_hv_en | output | 1 | High-voltage program enable |
| fl_rdy | input | 1 | Ready (1) / busy (0) from the flash |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has ended |
| error | output | 1 | Last run ended on a fault |
| err_addr | output | ADDR_W | Address where the fault occurred |

## Verification
A state machine that skips or reorders a setup step shows up at the port within one SETUP_CYC window. The data drivers, the control combination or the high-voltage line changes in the wrong order, or the strobe falls while one of them is missing. A faulty completion detector either starts the next strobe while the flash model still reports busy, or makes the verify read see a complemented bit and raise a false error within a few cycles. A wrong address walker or wrong erase timing appears as wrong bytes, a wrong pulse count or a wrong erase hold length. These are compared with values computed from the image formula once the run ends.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam logic [2:0] FM_IDLE  = 3'd0;
   localparam logic [2:0] FM_WRITE = 3'd1;
   localparam logic [2:0] FM_READ  = 3'd2;
   localparam logic [2:0] FM_ERASE = 3'd3;
   localparam logic [2:0] FM_SIG   = 3'd4;

   typedef enum logic [4:0] {
      S_IDLE, S_ID0, S_ID1, S_ER_SET, S_ER_HOLD, S_ER_REC, S_CHK,
      S_FETCH, S_W_ADDR, S_W_DATA, S_W_CTRL, S_W_HV, S_W_PULSE,
      S_W_WAIT, S_VERIFY, S_NEXT, S_FIN
   } seq_state_e;
endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] elapsed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                elapsed <= '0;
      else if (clr)              elapsed <= '0;
      else if (elapsed != '1)    elapsed <= elapsed + 1'b1;
   end
endmodule

// File: rtl/fps_walker.sv
module fps_walker #(
   parameter int ADDR_W = 12,
   parameter int LEN_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              empty,
   output logic              last
);
   logic [LEN_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         left_q <= '0;
      end else if (load) begin
         addr   <= base;
         left_q <= len;
      end else if (step) begin
         addr   <= addr + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   assign empty = (left_q == '0);
   assign last  = (left_q == LEN_W'(1));
endmodule

// File: rtl/fps_wdone.sv
module fps_wdone #(
   parameter bit RDY_SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic watch,
   input  logic poll_mode,
   input  logic wr_bit,
   input  logic rd_bit,
   input  logic rdy,
   output logic complete
);
   logic rdy_s;
   logic seen_busy;

   generate
      if (RDY_SYNC) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], rdy};
         end
         assign rdy_s = sync_q[1];
      end else begin : g_direct
         assign rdy_s = rdy;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 seen_busy <= 1'b0;
      else if (arm)               seen_busy <= 1'b0;
      else if (watch && !rdy_s)   seen_busy <= 1'b1;
   end

   assign complete = poll_mode ? (rd_bit == wr_bit) : (seen_busy && rdy_s);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import flash_seq_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          DATA_W      = 8,
   parameter int          SETUP_CYC   = 4,
   parameter int          STROBE_CYC  = 10,
   parameter int          ERASE_CYC   = 1_000_000,
   parameter int          TIMEOUT_CYC = 200_000,
   parameter int          POLL_BIT    = DATA_W - 1,
   parameter bit          RDY_SYNC    = 1'b1,
   parameter logic [11:0] SIG_BASE    = 12'h030,
   parameter logic [7:0]  SIG_ID0     = 8'h1E,
   parameter logic [7:0]  SIG_ID1     = 8'h51
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_ident,
   input  logic              cfg_erase,
   input  logic              cfg_verify,
   input  logic              cfg_hv,
   input  logic              cfg_poll,
   input  logic [ADDR_W-1:0] img_start,
   input  logic [ADDR_W:0]   img_len,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_ack,
   input  logic [DATA_W-1:0] fetch_data,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_dout,
   output logic              fl_dout_en,
   input  logic [DATA_W-1:0] fl_din,
   output logic [2:0]        fl_mode,
   output logic              fl_strobe_n,
   output logic              fl_hv_en,
   input  logic              fl_rdy,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [ADDR_W-1:0] err_addr
);
   localparam int LEN_W  = ADDR_W + 1;
   localparam int MAXC_A = (ERASE_CYC > TIMEOUT_CYC) ? ERASE_CYC : TIMEOUT_CYC;
   localparam int MAXC   = (MAXC_A > STROBE_CYC) ? MAXC_A : STROBE_CYC;
   localparam int CNT_W  = $clog2(MAXC + 2);
   localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(SIG_BASE);
   localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(SIG_BASE) + 1'b1;

   generate
      if (ADDR_W < 6)          begin : g_bad_aw   $error("ADDR_W must reach the signature block"); end
      if (DATA_W < 8)          begin : g_bad_dw   $error("DATA_W must hold a signature byte"); end
      if (SETUP_CYC < 1)       begin : g_bad_su   $error("SETUP_CYC must be at least 1"); end
      if (STROBE_CYC < 1)      begin : g_bad_st   $error("STROBE_CYC must be at least 1"); end
      if (ERASE_CYC < 1)       begin : g_bad_er   $error("ERASE_CYC must be at least 1"); end
      if (TIMEOUT_CYC < 2)     begin : g_bad_to   $error("TIMEOUT_CYC must be at least 2"); end
      if (POLL_BIT >= DATA_W)  begin : g_bad_pb   $error("POLL_BIT outside data width"); end
   endgenerate

   seq_state_e state_q, state_d;
   logic              cfg_ident_q, cfg_erase_q, cfg_verify_q, cfg_hv_q, cfg_poll_q;
   logic [DATA_W-1:0] byte_q;
   logic              done_q, err_q, err_pend_q;
   logic [ADDR_W-1:0] err_addr_q;

   logic [CNT_W-1:0]  elapsed;
   logic [CNT_W-1:0]  dur_m1;
   logic              step_end, timed_out;
   logic              walk_load, walk_step, walk_empty, walk_last;
   logic [ADDR_W-1:0] walk_addr;
   logic              wd_arm, wd_watch, wd_complete;
   logic              set_err;
   logic [ADDR_W-1:0] set_err_addr;
   logic              take_byte;

   fps_timer #(.W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .elapsed(elapsed)
   );

   fps_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
      .clk(clk), .rst_n(rst_n), .load(walk_load), .base(img_start), .len(img_len),
      .step(walk_step), .addr(walk_addr), .empty(walk_empty), .last(walk_last)
   );

   fps_wdone #(.RDY_SYNC(RDY_SYNC)) u_wdone (
      .clk(clk), .rst_n(rst_n), .arm(wd_arm), .watch(wd_watch), .poll_mode(cfg_poll_q),
      .wr_bit(byte_q[POLL_BIT]), .rd_bit(fl_din[POLL_BIT]), .rdy(fl_rdy),
      .complete(wd_complete)
   );

   always_comb begin
      case (state_q)
         S_ER_HOLD: dur_m1 = CNT_W'(ERASE_CYC - 1);
         S_W_PULSE: dur_m1 = CNT_W'(STROBE_CYC - 1);
         default:   dur_m1 = CNT_W'(SETUP_CYC - 1);
      endcase
   end
   assign step_end  = (elapsed == dur_m1);
   assign timed_out = (elapsed >= CNT_W'(TIMEOUT_CYC - 1));
   assign wd_watch  = (state_q == S_W_PULSE) || (state_q == S_W_WAIT);

   always_comb begin
      state_d      = state_q;
      walk_load    = 1'b0;
      walk_step    = 1'b0;
      wd_arm       = 1'b0;
      set_err      = 1'b0;
      set_err_addr = walk_addr;
      take_byte    = 1'b0;
      case (state_q)
         S_IDLE: if (start) begin
            walk_load = 1'b1;
            state_d   = cfg_ident ? S_ID0 : (cfg_erase ? S_ER_SET : S_CHK);
         end
         S_ID0: if (step_end) begin
            if (fl_din[7:0] != SIG_ID0) begin
               set_err = 1'b1; set_err_addr = SIG_A0; state_d = S_FIN;
            end else state_d = S_ID1;
         end
         S_ID1: if (step_end) begin
            if (fl_din[7:0] != SIG_ID1) begin
               set_err = 1'b1; set_err_addr = SIG_A1; state_d = S_FIN;
            end else state_d = cfg_erase_q ? S_ER_SET : S_CHK;
         end
         S_ER_SET:  if (step_end) state_d = S_ER_HOLD;
         S_ER_HOLD: if (step_end) state_d = S_ER_REC;
         S_ER_REC:  if (step_end) state_d = S_CHK;
         S_CHK:     state_d = walk_empty ? S_FIN : S_FETCH;
         S_FETCH: if (fetch_ack) begin
            take_byte = 1'b1;
            state_d   = S_W_ADDR;
         end
         S_W_ADDR: if (step_end) state_d = S_W_DATA;
         S_W_DATA: if (step_end) state_d = S_W_CTRL;
         S_W_CTRL: begin
            wd_arm = 1'b1;
            if (step_end) state_d = cfg_hv_q ? S_W_HV : S_W_PULSE;
         end
         S_W_HV:    if (step_end) state_d = S_W_PULSE;
         S_W_PULSE: if (step_end) state_d = S_W_WAIT;
         S_W_WAIT: begin
            if (wd_complete)    state_d = cfg_verify_q ? S_VERIFY : S_NEXT;
            else if (timed_out) begin set_err = 1'b1; state_d = S_FIN; end
         end
         S_VERIFY: if (step_end) begin
            if (fl_din != byte_q) begin set_err = 1'b1; state_d = S_FIN; end
            else state_d = S_NEXT;
         end
         S_NEXT: begin
            walk_step = 1'b1;
            state_d   = walk_last ? S_FIN : S_FETCH;
         end
         S_FIN:   state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= S_IDLE;
         cfg_ident_q  <= 1'b0;
         cfg_erase_q  <= 1'b0;
         cfg_verify_q <= 1'b0;
         cfg_hv_q     <= 1'b0;
         cfg_poll_q   <= 1'b0;
         byte_q       <= '0;
         done_q       <= 1'b0;
         err_q        <= 1'b0;
         err_pend_q   <= 1'b0;
         err_addr_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == S_IDLE && start) begin
            cfg_ident_q  <= cfg_ident;
            cfg_erase_q  <= cfg_erase;
            cfg_verify_q <= cfg_verify;
            cfg_hv_q     <= cfg_hv;
            cfg_poll_q   <= cfg_poll;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
            err_pend_q   <= 1'b0;
         end
         if (take_byte) byte_q <= fetch_data;
         if (set_err) begin
            err_pend_q <= 1'b1;
            err_addr_q <= set_err_addr;
         end
         if (state_q == S_FIN) begin
            done_q <= 1'b1;
            err_q  <= err_pend_q;
         end
      end
   end

   assign busy       = (state_q != S_IDLE);
   assign done       = done_q;
   assign error      = err_q;
   assign err_addr   = err_addr_q;
   assign fetch_req  = (state_q == S_FETCH);
   assign fetch_addr = walk_addr;
   assign fl_dout    = byte_q;

   always_comb begin
      fl_addr = walk_addr;
      if (state_q == S_ID0) fl_addr = SIG_A0;
      if (state_q == S_ID1) fl_addr = SIG_A1;
   end

   always_comb begin
      case (state_q)
         S_ID0, S_ID1:                  fl_mode = FM_SIG;
         S_ER_SET, S_ER_HOLD:           fl_mode = FM_ERASE;
         S_W_CTRL, S_W_HV, S_W_PULSE:   fl_mode = FM_WRITE;
         S_W_WAIT, S_VERIFY:            fl_mode = FM_READ;
         default:                       fl_mode = FM_IDLE;
      endcase
   end

   assign fl_dout_en  = (state_q == S_W_DATA) || (state_q == S_W_CTRL) ||
                        (state_q == S_W_HV)   || (state_q == S_W_PULSE);
   assign fl_strobe_n = !((state_q == S_ER_HOLD) || (state_q == S_W_PULSE));
   assign fl_hv_en    = cfg_hv_q && ((state_q == S_ER_SET) || (state_q == S_ER_HOLD) ||
                                     (state_q == S_W_HV)   || (state_q == S_W_PULSE));
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              error,
   input logic              fetch_req,
   input logic              fetch_ack,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [DATA_W-1:0] fl_dout,
   input logic              fl_dout_en,
   input logic [2:0]        fl_mode,
   input logic              fl_strobe_n,
   input logic              fl_hv_en,
   input logic              hv_cfg
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (fl_strobe_n && !fl_hv_en && fl_mode == 3'd0 && !fl_dout_en)); // R1
   AST_STROBE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_strobe_n |-> (fl_mode == 3'd1 || fl_mode == 3'd3)); // R4
   AST_PULSE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_strobe_n && fl_mode == 3'd1) |-> fl_dout_en); // R4
   AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_strobe_n && !$past(fl_strobe_n)) |-> ($stable(fl_addr) && $stable(fl_dout))); // R4
   AST_HV_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      fl_hv_en |-> hv_cfg); // R10
   AST_HV_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_strobe_n && hv_cfg) |-> fl_hv_en); // R10
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_mode == 3'd2 || fl_mode == 3'd4) |-> !fl_dout_en); // R6
   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr))); // R5
   AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done); // R12
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R12
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done)); // R12
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
   .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr),
   .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_mode(fl_mode),
   .fl_strobe_n(fl_strobe_n), .fl_hv_en(fl_hv_en), .hv_cfg(cfg_hv_q)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int SU = 2;
   localparam int ST = 3;
   localparam int ER = 20;
   localparam int TO = 40;
   localparam int BUSY_CYC = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cfg_ident = 1'b0, cfg_erase = 1'b0, cfg_verify = 1'b0, cfg_hv = 1'b0, cfg_poll = 1'b0;
   logic [AW-1:0] img_start = '0;
   logic [AW:0]   img_len = '0;
   logic          fetch_req, fetch_ack = 1'b0;
   logic [AW-1:0] fetch_addr;
   logic [DW-1:0] fetch_data = '0;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_dout, fl_din = '0;
   logic          fl_dout_en, fl_strobe_n, fl_hv_en, fl_rdy = 1'b1;
   logic [2:0]    fl_mode;
   logic          busy, done, error;
   logic [AW-1:0] err_addr;

   always #5 clk = ~clk;

   flash_prog_seq #(
      .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .STROBE_CYC(ST),
      .ERASE_CYC(ER), .TIMEOUT_CYC(TO)
   ) u_flash_prog_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_ident(cfg_ident), .cfg_erase(cfg_erase),
      .cfg_verify(cfg_verify), .cfg_hv(cfg_hv), .cfg_poll(cfg_poll), .img_start(img_start),
      .img_len(img_len), .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
      .fetch_data(fetch_data), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
      .fl_din(fl_din), .fl_mode(fl_mode), .fl_strobe_n(fl_strobe_n), .fl_hv_en(fl_hv_en),
      .fl_rdy(fl_rdy), .busy(busy), .done(done), .error(error), .err_addr(err_addr)
   );

   int checks = 0;
   int errs = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] img(input logic [7:0] a);
      return (a * 8'd29 + 8'd11) ^ 8'h5A;
   endfunction

   // flash and image-buffer model
   logic [7:0] mem [256];
   logic [7:0] sig0 = 8'h1E, sig1 = 8'h51;
   bit         stuck = 1'b0;
   int         fault_addr = -1;
   int         busy_cnt = 0, low_cnt = 0;
   int         wr_pulses = 0, erase_runs = 0, erase_len = 0;
   logic [7:0] exp_next, last_a, last_d;
   bit         hv_seen = 1'b0;
   logic       p_sn = 1'b1, p_den = 1'b0, p_hv = 1'b0;
   logic [2:0] p_mode = 3'd0;

   always @(negedge clk) begin
      if (fetch_req && !fetch_ack) begin
         fetch_ack  = 1'b1;
         fetch_data = img(fetch_addr);
      end else fetch_ack = 1'b0;

      if (fl_hv_en) hv_seen = 1'b1;
      if (fl_dout_en && !p_den)
         chk(fl_mode == 3'd0 && !fl_hv_en, "R4", "data before control", fl_mode, 0);
      if (fl_mode == 3'd1 && p_mode != 3'd1)
         chk(fl_dout_en && !fl_hv_en && fl_strobe_n, "R4", "control after data", {fl_dout_en, fl_hv_en, fl_strobe_n}, 3'b101);
      if (fl_hv_en && !p_hv && fl_mode == 3'd1)
         chk(fl_strobe_n, "R4", "hv before strobe", fl_strobe_n, 1);

      if (!fl_strobe_n && p_sn) begin
         low_cnt = 1;
         if (fl_mode == 3'd1) begin
            chk(busy_cnt == 0, "R7", "previous write complete", busy_cnt, 0);
            chk(fl_addr == exp_next, "R5", "write address", fl_addr, exp_next);
            chk(fl_dout == img(fl_addr), "R5", "write data", fl_dout, img(fl_addr));
            chk(fl_hv_en == cfg_hv, "R10", "hv at pulse", fl_hv_en, cfg_hv);
            exp_next = exp_next + 1'b1;
            wr_pulses++;
            if (int'(fl_addr) == fault_addr) mem[fl_addr] = mem[fl_addr] & (fl_dout ^ 8'h01);
            else                             mem[fl_addr] = mem[fl_addr] & fl_dout;
            last_a = fl_addr;
            last_d = fl_dout;
            busy_cnt = stuck ? 1_000_000 : BUSY_CYC;
         end
      end else begin
         if (!fl_strobe_n) low_cnt++;
         if (busy_cnt > 0 && !stuck) busy_cnt--;
      end
      if (fl_strobe_n && !p_sn) begin
         if (p_mode == 3'd3) begin
            erase_runs++;
            erase_len = low_cnt;
            if (low_cnt >= ER) for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
         end else
            chk(low_cnt == ST, "R4", "write pulse width", low_cnt, ST);
      end
      p_sn = fl_strobe_n; p_den = fl_dout_en; p_hv = fl_hv_en; p_mode = fl_mode;

      fl_rdy = (busy_cnt == 0);
      if (fl_mode == 3'd4)
         fl_din = (fl_addr == 8'h30) ? sig0 : (fl_addr == 8'h31) ? sig1 : 8'hFF;
      else if (busy_cnt > 0 && fl_addr == last_a)
         fl_din = {~last_d[7], last_d[6:0]};
      else
         fl_din = mem[fl_addr];
   end

   int wd = 0;
   bit wd_hit = 1'b0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150_000 && !wd_hit) begin
         wd_hit = 1'b1;
         chk(1'b0, "WD", "watchdog expired", wd, 150_000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   task automatic run(input string tag, input bit id, input bit er, input bit vf, input bit hv,
                      input bit pl, input logic [7:0] st, input int len, input bit exp_err,
                      input logic [7:0] exp_ea, input int exp_pulses, input int n_good);
      int guard;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hC3;
      cfg_ident = id; cfg_erase = er; cfg_verify = vf; cfg_hv = hv; cfg_poll = pl;
      img_start = st; img_len = 9'(len);
      wr_pulses = 0; erase_runs = 0; erase_len = 0; exp_next = st; hv_seen = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy && !done, "R12", {tag, " start clears done"}, {busy, done}, 2'b10);
      guard = 0;
      while (!done && guard < 5000) begin @(negedge clk); guard++; end
      chk(done, "R12", {tag, " run ends"}, done, 1);
      chk(error == exp_err, tag, "error flag", error, exp_err);
      if (exp_err) chk(err_addr == exp_ea, tag, "failing address", err_addr, exp_ea);
      chk(wr_pulses == exp_pulses, "R5", {tag, " pulse count"}, wr_pulses, exp_pulses);
      chk(hv_seen == (hv && (exp_pulses > 0 || (er && !(id && exp_err)))), "R10",
          {tag, " hv use"}, hv_seen, hv);
      if (er && !(id && exp_err)) begin
         chk(erase_runs == 1, "R3", {tag, " one erase"}, erase_runs, 1);
         chk(erase_len == ER, "R3", {tag, " erase hold"}, erase_len, ER);
         chk(mem[8'(st + exp_pulses)] == 8'hFF, "R9", {tag, " untouched byte"},
             mem[8'(st + exp_pulses)], 8'hFF);
      end else
         chk(erase_runs == 0, "R2", {tag, " no erase"}, erase_runs, 0);
      for (int i = 0; i < n_good; i++)
         chk(mem[8'(st + i)] == img(8'(st + i)), "R5", {tag, " stored byte"},
             mem[8'(st + i)], img(8'(st + i)));
      repeat (4) @(negedge clk);
      chk(done && !busy, "R12", {tag, " done held"}, {done, busy}, 2'b10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !error && fl_strobe_n && !fl_hv_en && fl_mode == 3'd0 && !fl_dout_en,
          "R1", "reset state", {busy, done, error, fl_strobe_n, fl_hv_en, fl_dout_en}, 6'b000100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && fl_strobe_n && fl_mode == 3'd0, "R1", "idle after reset", fl_mode, 0);

      for (int c = 0; c < 8; c++) begin
         // c[0]: R6 polling vs R7 ready/busy; c[1]: hv; c[2]: verify
         run(c[0] ? "R6" : "R7", 1'b1, 1'b1, c[2], c[1], c[0], 8'(8'h40 + c * 9), 3 + c,
             1'b0, 8'h00, 3 + c, 3 + c);
      end
      run("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hF0, 4, 1'b0, 8'h00, 4, 4);
      run("R11", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 0, 1'b0, 8'h00, 0, 0);

      sig0 = 8'h1F;
      run("R2", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h20, 4, 1'b1, 8'h30, 0, 0);
      sig0 = 8'h1E; sig1 = 8'h50;
      run("R2", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h20, 4, 1'b1, 8'h31, 0, 0);
      sig1 = 8'h51;

      stuck = 1'b1;
      run("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h60, 3, 1'b1, 8'h60, 1, 0);
      stuck = 1'b0; repeat (2) @(negedge clk);
      busy_cnt = 0;
      stuck = 1'b1;
      run("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h70, 3, 1'b1, 8'h70, 1, 0);
      stuck = 1'b0; busy_cnt = 0;

      fault_addr = 8'h82;
      run("R9", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h80, 6, 1'b1, 8'h82, 3, 2);
      fault_addr = -1;
      run("R9", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h90, 5, 1'b0, 8'h00, 5, 5);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule